// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block connects a clocked request port to an asynchronous byte-wide static memory that has a 19-bit address and a shared 8-bit data bus. The client raises `req` with `we`, `addr` and `wdata` while `ready` is high. The controller latches the request and drives the memory's active-low select, write and output strobes through a fixed sequence of clock cycles. A read result comes back on `rdata` together with a one-cycle `rvalid` pulse.

Timing is met by counting clock cycles and not by delay elements. With a 10 ns clock, the default cycle counts cover these memory limits:

- a 14 ns minimum write pulse;
- a 10 ns data setup before the write ends;
- a 20 ns access time;
- a 9 ns output release time.

A write keeps output-enable high, selects the chip and drives data for one full cycle, and then pulses write-enable. This way the memory never drives its pins while the controller does. After every read, one recovery cycle with all strobes high gives the memory time to release the bus.

The bidirectional bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`. The pad ring joins them into a tristate pin.

Top module: `sram_port_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rvalid` is 0 and `ready` is 1.
- R2: `ready` is 1 only while no access or recovery cycle is in progress. A `req` sampled while `ready` is 0 is dropped: it starts no access and changes neither the memory nor the latched address.
- R3: A write accepted at clock edge E0 gives: `mem_cs_n`=0 with `mem_we_n`=1 for the cycle after E0; `mem_we_n`=0 for the two cycles after E1 and E2; all strobes high and `ready`=1 after E3.
- R4: `mem_dq_oe` is 1 only during the three cycles of a write. During those cycles `mem_dq_out` equals the accepted `wdata`.
- R5: A read accepted at E0 holds `mem_cs_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 and `mem_dq_oe`=0 for the two cycles after E0 and E1.
- R6: `mem_dq_in` is sampled at E2 of a read. `rdata` shows that value and `rvalid` is 1 for exactly the one cycle after E2.
- R7: After E2 of a read there is one cycle with all strobes high, `mem_dq_oe`=0 and `ready`=0. A write requested during the read drives the bus no earlier than the cycle after E4.
- R8: `mem_addr` and `mem_dq_out` keep their accepted values for the whole access, even when `addr` and `wdata` change.
- R9: `mem_we_n`=0 only while `mem_cs_n`=0 and `mem_oe_n`=1. `mem_oe_n` and `mem_we_n` are never both 0.
- R10: When `mem_we_n` falls, `mem_cs_n` was already 0 and `mem_dq_oe` was already 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (10 ns period assumed for the default counts) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, request can be taken |
| rdata | output | 8 | Last captured read byte |
| rvalid | output | 1 | One-cycle pulse, `rdata` is new |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | 8 | Byte read from the memory pins |

## Verification
The checker watches the following on every cycle:

- the strobe combinations that must never occur (write-enable low without select, write and output enables both low, the bus driven outside a write);
- the exact width of the write-enable pulse;
- the select-before-write ordering;
- the single-cycle `rvalid` pulse;
- the recovery cycle after each read;
- the stable address during an access.

Only the bench scenarios can show the following:

- that the right byte lands in memory and comes back;
- that a request made while busy is really dropped;
- where the cycle-exact start and end of each access fall relative to the accepting edge;
- the asynchronous effect of reset in the middle of an access.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_RDACC  = 3'd3,
    ST_TURN   = 3'd4
  } ctl_state_e;

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The counter only moves when it is loaded or still above zero.
  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 2,
  parameter int RD_CYC       = 2,
  parameter int TURN_CYC     = 1,
  parameter int CNT_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             expired,
  output ctl_state_e       state_q,
  output ctl_state_e       state_d,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  // The timer holds (cycles - 1); zero means the last cycle of a phase.
  localparam logic [CNT_W-1:0] LD_WSETUP = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WPULSE = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RDACC  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC - 1);

  assign accept = req && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (we) begin
            state_d = ST_WSETUP;
            tmr_val = LD_WSETUP;
          end else begin
            state_d = ST_RDACC;
            tmr_val = LD_RDACC;
          end
        end
      end
      ST_WSETUP: begin
        if (expired) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WPULSE;
        end
      end
      ST_WPULSE: begin
        if (expired) state_d = ST_IDLE;
      end
      ST_RDACC: begin
        if (expired) begin
          state_d  = ST_TURN;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_TURN;
        end
      end
      ST_TURN: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_bus_stage.sv
module sram_bus_stage
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ctl_state_e        state_d,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic cs_on, we_on, oe_on, drv_on;
  logic wd_en;

  // Strobes are decoded from the next state and registered, so the pins
  // are glitch-free and change exactly on the clock edge.
  always_comb begin
    cs_on  = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_RDACC);
    we_on  = (state_d == ST_WPULSE);
    oe_on  = (state_d == ST_RDACC);
    drv_on = (state_d == ST_WSETUP) || (state_d == ST_WPULSE);
  end

  assign wd_en = accept & we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rvalid    <= 1'b0;
    end else begin
      mem_cs_n  <= ~cs_on;
      mem_we_n  <= ~we_on;
      mem_oe_n  <= ~oe_on;
      mem_dq_oe <= drv_on;
      rvalid    <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_addr <= '0;
    else if (accept) mem_addr <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_dq_out <= '0;
    else if (wd_en) mem_dq_out <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= mem_dq_in;
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 2,
  parameter int RD_CYC       = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_A   = (WR_SETUP_CYC > WR_PULSE_CYC) ? WR_SETUP_CYC : WR_PULSE_CYC;
  localparam int MAX_B   = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctl_state_e       state_q, state_d;
  logic             accept, capture, tmr_load, expired;
  logic [CNT_W-1:0] tmr_val;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_ctl_fsm #(
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .RD_CYC       (RD_CYC),
    .TURN_CYC     (TURN_CYC),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .expired  (expired),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  sram_bus_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .state_d    (state_d),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

  assign ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W       = 19,
  parameter int WR_PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  // Length of the current write-enable low run, counted in the checker.
  logic [15:0] we_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_run <= '0;
    else if (!mem_we_n) we_low_run <= we_low_run + 16'd1;
    else                we_low_run <= '0;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run == 16'(WR_PULSE_CYC)));

  assert_drive_only_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  assert_read_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n && !mem_dq_oe));

  assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_read_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!ready && mem_cs_n && !mem_dq_oe));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_we_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  assert_cs_before_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_dq_oe)));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .WR_PULSE_CYC (WR_PULSE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .rvalid    (rvalid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_port_ctrl.sv
`timescale 1ns/1ps
module tb_sram_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  sram_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: 16 bytes indexed by the low address nibble.
  // An unwritten byte reads as 8'hA0 | nibble.
  logic [7:0]  bmem [16];
  logic [15:0] seen;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!mem_cs_n && !mem_we_n) begin
      seen[mem_addr[3:0]] <= 1'b1;
      bmem[mem_addr[3:0]] <= mem_dq_out;
    end
  end

  always_comb begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_in = seen[mem_addr[3:0]] ? bmem[mem_addr[3:0]] : (8'hA0 | {4'h0, mem_addr[3:0]});
    else
      mem_dq_in = 8'hEE;
  end

  // {cs_n, we_n, oe_n, dq_oe}
  wire [3:0] strb = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe};
  localparam logic [3:0] S_IDLE  = 4'b1110;
  localparam logic [3:0] S_WSET  = 4'b0111;
  localparam logic [3:0] S_WPUL  = 4'b0011;
  localparam logic [3:0] S_READ  = 4'b0100;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 strobes in reset", 32'(strb), 32'(S_IDLE));
    chk("R1 ready in reset", 32'(ready), 32'd1);
    chk("R1 rvalid in reset", 32'(rvalid), 32'd0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; addr = ~a; wdata = ~d;
    chk("R3 write setup strobes", 32'(strb), 32'(S_WSET));
    chk("R2 busy during write", 32'(ready), 32'd0);
    chk("R8 write addr latched", 32'(mem_addr), 32'(a));
    chk("R4 write data driven", 32'(mem_dq_out), 32'(d));
    @(negedge clk);
    chk("R3 write pulse 1", 32'(strb), 32'(S_WPUL));
    chk("R9 oe high in write", 32'(mem_oe_n), 32'd1);
    chk("R8 addr held", 32'(mem_addr), 32'(a));
    @(negedge clk);
    chk("R3 write pulse 2", 32'(strb), 32'(S_WPUL));
    chk("R8 data held", 32'(mem_dq_out), 32'(d));
    @(negedge clk);
    chk("R3 write end strobes", 32'(strb), 32'(S_IDLE));
    chk("R3 ready after write", 32'(ready), 32'd1);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; addr = ~a;
    chk("R5 read strobes 1", 32'(strb), 32'(S_READ));
    chk("R8 read addr latched", 32'(mem_addr), 32'(a));
    @(negedge clk);
    chk("R5 read strobes 2", 32'(strb), 32'(S_READ));
    chk("R6 no early rvalid", 32'(rvalid), 32'd0);
    @(negedge clk);
    chk("R6 rvalid pulse", 32'(rvalid), 32'd1);
    chk("R6 rdata", 32'(rdata), 32'(exp));
    chk("R7 recovery strobes", 32'(strb), 32'(S_IDLE));
    chk("R7 busy in recovery", 32'(ready), 32'd0);
    @(negedge clk);
    chk("R6 rvalid one cycle", 32'(rvalid), 32'd0);
    chk("R7 ready after recovery", 32'(ready), 32'd1);
  endtask

  // Read request held high through a write: it must be dropped.
  task automatic t_busy_ignored();
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 19'h12345; wdata = 8'h3C;
    @(negedge clk); we = 1'b0; addr = 19'h2ABC3;
    @(negedge clk);
    chk("R2 write continues", 32'(strb), 32'(S_WPUL));
    chk("R2 addr kept", 32'(mem_addr), 32'h12345);
    @(negedge clk);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk("R2 no extra access", 32'(strb), 32'(S_IDLE));
    chk("R2 no rvalid", 32'(rvalid), 32'd0);
    chk("R2 latched addr unchanged", 32'(mem_addr), 32'h12345);
    @(negedge clk);
    chk("R2 still no rvalid", 32'(rvalid), 32'd0);
  endtask

  // Read followed by a pending write: bus turnaround.
  task automatic t_read_then_write();
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 19'h12345;
    @(negedge clk); we = 1'b1; addr = 19'h2ABC3; wdata = 8'hC7;
    @(negedge clk);
    @(negedge clk);
    chk("R6 rdata before turn", 32'(rdata), 32'h3C);
    chk("R7 turn strobes", 32'(strb), 32'(S_IDLE));
    chk("R7 turn busy", 32'(ready), 32'd0);
    @(negedge clk);
    chk("R7 bus idle after turn", 32'(mem_dq_oe), 32'd0);
    @(negedge clk); req = 1'b0;
    chk("R7 write starts", 32'(strb), 32'(S_WSET));
    chk("R7 write addr", 32'(mem_addr), 32'h2ABC3);
    @(negedge clk);
    chk("R10 we low after cs", 32'(strb), 32'(S_WPUL));
    @(negedge clk);
    @(negedge clk);
    chk("R3 write done", 32'(strb), 32'(S_IDLE));
  endtask

  task automatic t_async_reset();
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 19'h00007; wdata = 8'h11;
    @(negedge clk); req = 1'b0;
    chk("R1 write started", 32'(strb), 32'(S_WSET));
    rst_n = 1'b0;
    #1;
    chk("R1 strobes on reset", 32'(strb), 32'(S_IDLE));
    chk("R1 ready on reset", 32'(ready), 32'd1);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'(strb), 32'(S_IDLE));
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_write(19'h7FFFF, 8'h96);
    t_read (19'h7FFFF, 8'h96);
    t_read (19'h00000, 8'hA0);
    t_write(19'h00000, 8'h5A);
    t_read (19'h00000, 8'h5A);
    t_busy_ignored();
    t_read (19'h2ABC3, 8'hA3);
    t_read_then_write();
    t_read (19'h2ABC3, 8'hC7);
    t_async_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule